// File: doc/BRIEF.md
# Tunable-Capacitor Serial Control Receiver

This block is a write-only slave on a three-wire serial link that sets a 32-step tuning element. The master raises an enable line, then presents one data bit per serial clock, most significant bit first. The receiver samples the data line on each rising serial clock edge while the enable is high. It never counts bits: it keeps only the eight most recent bits. On the falling edge of the enable it commits that byte to its outputs. A transfer of any length therefore works, and only its last eight bits take effect.

The serial pins are oversampled in the system clock domain. Each pin passes through a two-flop synchronizer, and edges are found by comparing the synchronized level with its previous value. The committed byte drives a 5-bit tuning code and an active-high standby output. Whenever a commit changes the code, the standby bit or both, a busy flag stays high for a parameterised number of system clocks. The surrounding logic uses it to wait for the tuning element to settle.

Top module: `tunecap_serial_rx`

## Requirements
- R1: While reset is asserted and immediately after it, the tuning code is 0, standby is 0 and busy is 0.
- R2: A data bit is captured only on a rising serial clock edge with the enable high. Bits arrive most significant first, and the last captured bit lands in bit 0 of the received byte.
- R3: Only the eight most recently captured bits are retained. In a longer transfer the earlier bits are discarded.
- R4: The outputs do not change while a transfer is shifting in. They change only as a result of a falling enable edge.
- R5: Serial clock edges seen while the enable is low capture nothing and leave the received byte untouched.
- R6: A transfer with fewer than eight clocks still commits the whole current byte: the new bits plus the older bits shifted up.
- R7: In the committed byte, bit 5 drives standby (1 = standby, 0 = normal) and bits 4 to 0 drive the tuning code as a plain binary value from 0 to 31. Bits 7 and 6 have no effect on any output.
- R8: A commit that changes the code or standby raises busy for exactly BUSY_CYCLES system clocks, starting in the same cycle as the output change. A commit that changes neither leaves busy low.
- R9: The outputs take the new value at the second system clock edge after the edge that first samples the enable pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock pin |
| ser_dat_i | input | 1 | Serial data pin |
| ser_en_i | input | 1 | Serial enable pin, active high framing |
| tune_code_o | output | 5 | Committed tuning code |
| standby_o | output | 1 | Committed standby request, active high |
| busy_o | output | 1 | Settling window after a committed change |

## Verification
The bench builds the receiver with BUSY_CYCLES set to 6 and keeps two synchronizer stages. With this setting a whole settling window fits between transfers, so its exact length is counted on every commit. The commit that changes only standby and the commit that changes nothing are both reached within a short run. The serial clock runs at one sixth of the system clock, so the commit latency and each capture edge are observed cycle by cycle against the reference model.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    localparam int WORD_W   = 8;
    localparam int CODE_W   = 5;
    localparam int STBY_BIT = 5;

    typedef struct packed {
        logic              standby;
        logic [CODE_W-1:0] code;
    } tune_word_t;

    function automatic tune_word_t decode_word(input logic [WORD_W-1:0] w);
        tune_word_t t;
        t.standby = w[STBY_BIT];
        t.code    = w[CODE_W-1:0];
        return t;
    endfunction
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign dout_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_shifter.sv
module tcap_shifter
    import tcap_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_s_i,
    input  logic              sen_s_i,
    input  logic              sdat_s_i,
    output logic [WORD_W-1:0] shift_o,
    output logic              shift_en_o,
    output logic              en_fall_o
);
    typedef struct packed {
        logic              sclk_prev;
        logic              sen_prev;
        logic [WORD_W-1:0] shift;
    } shf_state_t;

    shf_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s_i;
        st_d.sen_prev  = sen_s_i;
        shift_en_o     = sclk_s_i && !st_q.sclk_prev && sen_s_i;
        en_fall_o      = !sen_s_i && st_q.sen_prev;
        if (shift_en_o) begin
            st_d.shift = {st_q.shift[WORD_W-2:0], sdat_s_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign shift_o = st_q.shift;
endmodule

// File: rtl/tcap_commit.sv
module tcap_commit
    import tcap_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CODE_W-1:0] code_o,
    output logic              standby_o,
    output logic              busy_o,
    output logic              change_o
);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        tune_word_t        cur;
        logic [BUSY_W-1:0] cnt;
    } cmt_state_t;

    cmt_state_t st_d, st_q;
    tune_word_t incoming;

    always_comb begin
        st_d     = st_q;
        incoming = decode_word(word_i);
        change_o = commit_i && (incoming != st_q.cur);
        if (commit_i) begin
            st_d.cur = incoming;
        end
        if (change_o) begin
            st_d.cnt = BUSY_W'(BUSY_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign code_o    = st_q.cur.code;
    assign standby_o = st_q.cur.standby;
    assign busy_o    = (st_q.cnt != '0);
endmodule

// File: rtl/tunecap_serial_rx.sv
module tunecap_serial_rx
    import tcap_pkg::*;
#(
    parameter int BUSY_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_en_i,
    output logic [CODE_W-1:0] tune_code_o,
    output logic              standby_o,
    output logic              busy_o
);
    localparam int NPINS = 3;

    logic [NPINS-1:0]  pins_raw, pins_s;
    logic              sclk_s, sdat_s, sen_s;
    logic [WORD_W-1:0] shift_word;
    logic              shift_en, en_fall, cmt_change;

    assign pins_raw = {ser_en_i, ser_dat_i, ser_clk_i};

    for (genvar i = 0; i < NPINS; i++) begin : g_sync
        tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .din_i (pins_raw[i]),
            .dout_o(pins_s[i])
        );
    end

    assign sclk_s = pins_s[0];
    assign sdat_s = pins_s[1];
    assign sen_s  = pins_s[2];

    tcap_shifter u_shf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sclk_s_i  (sclk_s),
        .sen_s_i   (sen_s),
        .sdat_s_i  (sdat_s),
        .shift_o   (shift_word),
        .shift_en_o(shift_en),
        .en_fall_o (en_fall)
    );

    tcap_commit #(.BUSY_CYCLES(BUSY_CYCLES)) u_cmt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .commit_i (en_fall),
        .word_i   (shift_word),
        .code_o   (tune_code_o),
        .standby_o(standby_o),
        .busy_o   (busy_o),
        .change_o (cmt_change)
    );
endmodule

// File: rtl/tunecap_serial_rx_chk.sv
module tunecap_serial_rx_chk
    import tcap_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CODE_W-1:0] tune_code_o,
    input logic              standby_o,
    input logic              busy_o,
    input logic [WORD_W-1:0] shift_word,
    input logic              shift_en,
    input logic              en_fall,
    input logic              sdat_s,
    input logic              cmt_change
);
    localparam int CW = $clog2(BUSY_CYCLES + 2);
    logic [CW-1:0] busy_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + 1'b1;
        else             busy_run <= '0;
    end

    // R1
    always_comb begin
        if (!rst_ni) begin
            reset_state_chk: assert (tune_code_o == '0 && !standby_o && !busy_o);
        end
    end

    // R2
    capture_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_en |=> shift_word[0] == $past(sdat_s));

    // R5
    shift_only_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(shift_word) |-> $past(shift_en));

    // R4
    code_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable({standby_o, tune_code_o}) |-> $past(en_fall));

    // R8
    busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmt_change |=> busy_o);

    // R8
    busy_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_run <= CW'(BUSY_CYCLES));
endmodule

bind tunecap_serial_rx tunecap_serial_rx_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tune_code_o(tune_code_o),
    .standby_o  (standby_o),
    .busy_o     (busy_o),
    .shift_word (shift_word),
    .shift_en   (shift_en),
    .en_fall    (en_fall),
    .sdat_s     (sdat_s),
    .cmt_change (cmt_change)
);

// File: tb/tunecap_serial_rx_tb.sv
module tunecap_serial_rx_tb;
    localparam int BUSY = 6;

    logic       clk = 0, rst_n = 0;
    logic       sclk = 0, sdat = 0, sen = 0;
    logic [4:0] code;
    logic       stby, busy;

    int checks = 0, fails = 0, cycles = 0;
    int prev_code = 0, prev_stby = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tunecap_serial_rx #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_en_i(sen), .tune_code_o(code), .standby_o(stby), .busy_o(busy)
    );

    // behavioural reference: pin history, byte, outputs, settle counter
    bit h_c[4], h_d[4], h_e[4];
    int m_byte = 0, m_code = 0, m_stby = 0, m_cnt = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin h_c[i] = 0; h_d[i] = 0; h_e[i] = 0; end
            m_byte = 0; m_code = 0; m_stby = 0; m_cnt = 0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                h_c[i] = h_c[i-1]; h_d[i] = h_d[i-1]; h_e[i] = h_e[i-1];
            end
            h_c[0] = sclk; h_d[0] = sdat; h_e[0] = sen;
            if (m_cnt > 0) m_cnt = m_cnt - 1;
            if (!h_e[2] && h_e[3]) begin
                if ((m_byte % 32) != m_code || ((m_byte / 32) % 2) != m_stby) m_cnt = BUSY;
                m_code = m_byte % 32;
                m_stby = (m_byte / 32) % 2;
            end else if (h_c[2] && !h_c[3] && h_e[2]) begin
                m_byte = (m_byte * 2 + int'(h_d[2])) % 256;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check("R9 model code", int'(code), m_code);
            check("R7 model standby", int'(stby), m_stby);
            check("R8 model busy", int'(busy), int'(m_cnt != 0));
        end
    end

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        wait (cycles > 100000);
        check("watchdog", 1, 0);
        finish_run();
    end

    task automatic xfer(input string tag, input int bits, input int n,
                        input int exp_code, input int exp_stby, input int exp_busy);
        int bc;
        @(negedge clk); sen = 1; sclk = 0;
        repeat (3) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = bits[i];
            repeat (3) @(negedge clk);
            sclk = 1;
            repeat (3) @(negedge clk);
            sclk = 0;
        end
        repeat (4) @(negedge clk);
        check({tag, " R4 code held"}, int'(code), prev_code);
        check({tag, " R4 standby held"}, int'(stby), prev_stby);
        sen = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check({tag, " R9 early code"}, int'(code), prev_code);
        @(posedge clk); @(negedge clk);
        check({tag, " R9 code"}, int'(code), exp_code);
        check({tag, " R7 standby"}, int'(stby), exp_stby);
        bc = int'(busy);
        repeat (28) begin @(negedge clk); bc += int'(busy); end
        check({tag, " R8 busy cycles"}, bc, exp_busy);
        prev_code = exp_code; prev_stby = exp_stby;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 code", int'(code), 0);
        check("R1 standby", int'(stby), 0);
        check("R1 busy", int'(busy), 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check("R1 code after release", int'(code), 0);

        xfer("R2 byte 0x0A", 'h0A, 8, 10, 0, BUSY);
        xfer("R2 byte 0x3F", 'h3F, 8, 31, 1, BUSY);
        xfer("R7 top bits 0xC7", 'hC7, 8, 7, 0, BUSY);
        xfer("R3 long 0xA53", 'hA53, 12, 19, 0, BUSY);
        xfer("R6 short 101", 'h5, 3, 29, 0, BUSY);

        // R5: clocks with enable low must not shift ones in
        @(negedge clk); sdat = 1;
        for (int i = 0; i < 8; i++) begin
            repeat (3) @(negedge clk); sclk = 1;
            repeat (3) @(negedge clk); sclk = 0;
        end
        xfer("R5 ignored clocks", 0, 0, 29, 0, 0);
        xfer("R8 standby only", 'h3D, 8, 29, 1, BUSY);
        xfer("R8 no change", 'h3D, 8, 29, 1, 0);
        xfer("R7 zero", 'hC0, 8, 0, 0, BUSY);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule